// File: doc/BRIEF.md
# Fetch-Slot Refresh DRAM Controller

This block sits between an 8-bit CPU bus and a bank of multiplexed-address DRAM. It samples the CPU's cycle-type lines on each clock and turns every memory cycle into DRAM strobes. An opcode fetch, a data read and a data write all get the same row/column sequence: the row strobe falls with the row half of the address, the multiplexer then moves to the column half, and the column strobe follows one clock later. The column strobe is never asserted unless the row strobe is already active.

Refresh is never scheduled by the controller. When the CPU signals its refresh phase, which comes in the spare time at the end of each opcode fetch, the controller issues a row-strobe-only cycle using whatever row address the CPU places on the low address lines. Because that row comes from the CPU's own incrementing register, the block needs no refresh counter or timer and never delays a CPU access. A hold input from the wait-state logic freezes the strobe sequence for as long as it is asserted. The end of the CPU cycle releases all strobes.

Top module: `dram_slot_refresh`

## Requirements
- R1: While rstN is low, rasN, casN and weN are high and muxSel is 0.
- R2: A clock edge that samples cycMemN low, cycRefreshN high, cycHoldN high and at least one of cycRdN, cycWrN, cycFetchN low while the block is idle drives rasN low, with muxSel 0 so that dramAddr equals cpuAddr[MUX_W-1:0].
- R3: The edge after RAS falls sets muxSel to 1, so that dramAddr equals cpuAddr[2*MUX_W-1:MUX_W]. casN falls on the following edge and only while rasN is low and muxSel is 1.
- R4: An opcode fetch (cycFetchN low) produces exactly the same row/column strobe sequence and timing as a data read.
- R5: A clock edge that samples cycMemN and cycRefreshN both low while idle starts a refresh: rasN goes low with dramAddr equal to cpuAddr[MUX_W-1:0], and casN stays high for the whole refresh.
- R6: In a write cycle (cycWrN low when the cycle starts), weN falls on the same edge as muxSel rises, one clock before casN falls. weN stays high in reads, fetches and refreshes.
- R7: At an edge that samples cycHoldN low while cycMemN is low, rasN, casN, weN and muxSel keep their values.
- R8: The edge after cycMemN is sampled high drives rasN, casN and weN high and muxSel to 0.
- R9: A fetch followed by its refresh phase gives exactly one row-strobe-only pulse, and that refresh never overlaps a data access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycMemN | input | 1 | Active-low memory cycle in progress |
| cycRdN | input | 1 | Active-low read cycle |
| cycWrN | input | 1 | Active-low write cycle |
| cycFetchN | input | 1 | Active-low opcode fetch cycle |
| cycRefreshN | input | 1 | Active-low CPU refresh phase |
| cycHoldN | input | 1 | Active-low hold from wait-state logic |
| cpuAddr | input | 2*MUX_W | CPU address bus (refresh row on low bits) |
| rasN | output | 1 | Active-low DRAM row strobe |
| casN | output | 1 | Active-low DRAM column strobe |
| weN | output | 1 | Active-low DRAM write enable |
| muxSel | output | 1 | Address mux select: 0 row, 1 column |
| dramAddr | output | MUX_W | Multiplexed DRAM address |

## Verification
The hardest case to reach is a hold that lands in the middle of a strobe sequence. The bench asserts cycHoldN on the falling edge right after RAS has dropped and keeps it low for several clocks. During that time it checks that the multiplexer does not move and that CAS stays high, then it lets the sequence finish and compares the column address. Fetches are each paired with a refresh phase whose row differs from the fetch row. The scoreboard can therefore tell a RAS-only pulse apart from an access, and it can count refresh pulses against fetches.

// File: rtl/dram_slot_refresh_pkg.sv
package dram_slot_refresh_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ROW,
    PH_COL,
    PH_STROBE,
    PH_REFRESH
  } phase_t;

  typedef struct packed {
    logic rowOn;
    logic colOn;
    logic colSel;
    logic wrOn;
  } strobe_t;
endpackage

// File: rtl/dram_slot_ctrl.sv
module dram_slot_ctrl
  import dram_slot_refresh_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cycMemN,
  input  logic    cycRdN,
  input  logic    cycWrN,
  input  logic    cycFetchN,
  input  logic    cycRefreshN,
  input  logic    cycHoldN,
  output strobe_t nextStrobe
);
  phase_t phaseQ, phaseD;
  logic   writeQ, writeD;
  logic   accessReq;

  assign accessReq = !cycRdN || !cycWrN || !cycFetchN;

  always_comb begin
    phaseD = phaseQ;
    writeD = writeQ;
    if (cycMemN) begin
      phaseD = PH_IDLE;
      writeD = 1'b0;
    end else if (cycHoldN) begin
      unique case (phaseQ)
        PH_IDLE: begin
          if (!cycRefreshN) begin
            phaseD = PH_REFRESH;
            writeD = 1'b0;
          end else if (accessReq) begin
            phaseD = PH_ROW;
            writeD = !cycWrN;
          end
        end
        PH_ROW:     phaseD = PH_COL;
        PH_COL:     phaseD = PH_STROBE;
        PH_STROBE:  phaseD = PH_STROBE;
        PH_REFRESH: phaseD = PH_REFRESH;
        default:    phaseD = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      writeQ <= 1'b0;
    end else begin
      phaseQ <= phaseD;
      writeQ <= writeD;
    end
  end

  always_comb begin
    nextStrobe.rowOn  = (phaseD != PH_IDLE);
    nextStrobe.colSel = (phaseD == PH_COL) || (phaseD == PH_STROBE);
    nextStrobe.colOn  = (phaseD == PH_STROBE);
    nextStrobe.wrOn   = nextStrobe.colSel && writeD;
  end
endmodule

// File: rtl/dram_slot_datapath.sv
module dram_slot_datapath
  import dram_slot_refresh_pkg::*;
#(
  parameter int MUX_W = 8,
  localparam int CPU_AW = 2 * MUX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           nextStrobe,
  input  logic [CPU_AW-1:0] cpuAddr,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              muxSel,
  output logic [MUX_W-1:0]  dramAddr
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasN   <= 1'b1;
      casN   <= 1'b1;
      weN    <= 1'b1;
      muxSel <= 1'b0;
    end else begin
      rasN   <= !nextStrobe.rowOn;
      casN   <= !nextStrobe.colOn;
      weN    <= !nextStrobe.wrOn;
      muxSel <= nextStrobe.colSel;
    end
  end

  assign dramAddr = muxSel ? cpuAddr[CPU_AW-1:MUX_W] : cpuAddr[MUX_W-1:0];
endmodule

// File: rtl/dram_slot_refresh.sv
module dram_slot_refresh
  import dram_slot_refresh_pkg::*;
#(
  parameter int MUX_W = 8,
  localparam int CPU_AW = 2 * MUX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycMemN,
  input  logic              cycRdN,
  input  logic              cycWrN,
  input  logic              cycFetchN,
  input  logic              cycRefreshN,
  input  logic              cycHoldN,
  input  logic [CPU_AW-1:0] cpuAddr,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              muxSel,
  output logic [MUX_W-1:0]  dramAddr
);
  strobe_t nextStrobe;

  dram_slot_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cycMemN(cycMemN), .cycRdN(cycRdN),
    .cycWrN(cycWrN), .cycFetchN(cycFetchN), .cycRefreshN(cycRefreshN),
    .cycHoldN(cycHoldN), .nextStrobe(nextStrobe)
  );

  dram_slot_datapath #(.MUX_W(MUX_W)) dp_i (
    .clk(clk), .rstN(rstN), .nextStrobe(nextStrobe), .cpuAddr(cpuAddr),
    .rasN(rasN), .casN(casN), .weN(weN), .muxSel(muxSel), .dramAddr(dramAddr)
  );
endmodule

// File: rtl/dram_slot_refresh_chk.sv
module dram_slot_refresh_chk (
  input logic clk,
  input logic rstN,
  input logic cycMemN,
  input logic cycWrN,
  input logic cycRefreshN,
  input logic cycHoldN,
  input logic rasN,
  input logic casN,
  input logic weN,
  input logic muxSel
);
  // R3: column strobe only inside an active row strobe
  p_cas_in_ras_r3: assert property (@(posedge clk) disable iff (!rstN)
    !casN |-> !rasN);

  // R3: mux moved to column one clock before CAS falls
  p_mux_before_cas_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> $past(muxSel));

  // R6: early write, weN already low when CAS falls in a write
  p_early_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(casN) && !weN) |-> $past(!weN));

  // R6: write enable only starts in a write cycle
  p_we_only_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(weN) |-> $past(!cycWrN));

  // R5: refresh started from idle never raises CAS
  p_refresh_no_cas_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!cycMemN && !cycRefreshN && rasN) |=> casN);

  // R7: hold freezes strobes and mux
  p_hold_freeze_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!cycMemN && !cycHoldN) |=> ($stable(rasN) && $stable(casN) && $stable(weN) && $stable(muxSel)));

  // R8: cycle end releases everything
  p_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    cycMemN |=> (rasN && casN && weN && !muxSel));
endmodule

bind dram_slot_refresh dram_slot_refresh_chk chk_i (
  .clk(clk), .rstN(rstN), .cycMemN(cycMemN), .cycWrN(cycWrN),
  .cycRefreshN(cycRefreshN), .cycHoldN(cycHoldN), .rasN(rasN),
  .casN(casN), .weN(weN), .muxSel(muxSel)
);

// File: tb/dram_slot_refresh_tb_top.sv
module dram_slot_refresh_tb_top;
  localparam int MW = 8;
  localparam int KIND_READ  = 0;
  localparam int KIND_WRITE = 1;
  localparam int KIND_REF   = 2;

  typedef struct {
    int          kind;
    logic [MW-1:0] row;
    logic [MW-1:0] col;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycMemN = 1'b1, cycRdN = 1'b1, cycWrN = 1'b1, cycFetchN = 1'b1;
  logic cycRefreshN = 1'b1, cycHoldN = 1'b1;
  logic [2*MW-1:0] cpuAddr = '0;
  logic rasN, casN, weN, muxSel;
  logic [MW-1:0] dramAddr;

  int checkCount = 0;
  int failCount = 0;
  int fetchCount = 0;
  int refreshSeen = 0;
  item_t expQ[$];

  always #2 clk = ~clk;

  dram_slot_refresh #(.MUX_W(MW)) dut_i (
    .clk(clk), .rstN(rstN), .cycMemN(cycMemN), .cycRdN(cycRdN),
    .cycWrN(cycWrN), .cycFetchN(cycFetchN), .cycRefreshN(cycRefreshN),
    .cycHoldN(cycHoldN), .cpuAddr(cpuAddr), .rasN(rasN), .casN(casN),
    .weN(weN), .muxSel(muxSel), .dramAddr(dramAddr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: rebuild each RAS pulse and compare with the expected queue
  logic rasPrev = 1'b1, casPrev = 1'b1, wePrev = 1'b1;
  logic casSeen = 1'b0, weAtCas = 1'b1, weEarly = 1'b1;
  logic [MW-1:0] obsRow = '0, obsCol = '0;
  always @(posedge clk) begin
    #1;
    if (rstN) begin
      if (rasPrev && !rasN) begin
        obsRow  = dramAddr;
        casSeen = 1'b0;
        weAtCas = 1'b1;
        check(!muxSel, "R2", "mux at RAS fall", muxSel, 0);
      end
      if (casPrev && !casN) begin
        casSeen = 1'b1;
        obsCol  = dramAddr;
        weAtCas = weN;
        weEarly = wePrev;
        check(muxSel, "R3", "mux at CAS fall", muxSel, 1);
      end
      if (!rasPrev && rasN) begin
        item_t e;
        int k;
        k = !casSeen ? KIND_REF : (weAtCas ? KIND_READ : KIND_WRITE);
        if (k == KIND_REF) refreshSeen++;
        if (expQ.size() == 0) begin
          check(1'b0, "R9", "unexpected RAS pulse", k, -1);
        end else begin
          e = expQ.pop_front();
          check(k == e.kind, (e.kind == KIND_REF) ? "R5" : "R6", "cycle kind", k, e.kind);
          check(obsRow == e.row, (e.kind == KIND_REF) ? "R5" : "R2", "row address", obsRow, e.row);
          if (e.kind != KIND_REF)
            check(obsCol == e.col, "R3", "column address", obsCol, e.col);
          if (e.kind == KIND_WRITE)
            check(!weEarly, "R6", "weN low before CAS", weEarly, 0);
        end
      end
      rasPrev = rasN;
      casPrev = casN;
      wePrev  = weN;
    end
  end

  // kind: 0 read, 1 write, 3 fetch
  task automatic doAccess(input int kind, input logic [2*MW-1:0] a, input int holdClks);
    item_t e;
    @(negedge clk);
    cycMemN = 1'b0;
    cycRdN = !(kind == 0 || kind == 3);
    cycWrN = !(kind == 1);
    cycFetchN = !(kind == 3);
    cpuAddr = a;
    e.kind = (kind == 1) ? KIND_WRITE : KIND_READ;
    e.row = a[MW-1:0];
    e.col = a[2*MW-1:MW];
    expQ.push_back(e);
    @(negedge clk);
    if (holdClks > 0) begin
      cycHoldN = 1'b0;
      for (int i = 0; i < holdClks; i++) begin
        @(negedge clk);
        check(!rasN && casN && !muxSel && weN, "R7", "strobes frozen in hold",
              {rasN, casN, muxSel, weN}, 4'b0101);
      end
      cycHoldN = 1'b1;
    end
    @(negedge clk);
    @(negedge clk);
    cycMemN = 1'b1; cycRdN = 1'b1; cycWrN = 1'b1; cycFetchN = 1'b1;
    @(negedge clk);
    check(rasN && casN && weN && !muxSel, "R8", "release after cycle end",
          {rasN, casN, weN, muxSel}, 4'b1110);
  endtask

  task automatic doRefresh(input logic [MW-1:0] r, input int len);
    item_t e;
    @(negedge clk);
    cycMemN = 1'b0;
    cycRefreshN = 1'b0;
    cpuAddr = {8'hA5, r};
    e.kind = KIND_REF;
    e.row = r;
    e.col = '0;
    expQ.push_back(e);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      check(!rasN && casN, "R5", "RAS-only during refresh", {rasN, casN}, 2'b01);
    end
    cycMemN = 1'b1;
    cycRefreshN = 1'b1;
    @(negedge clk);
  endtask

  task automatic doFetch(input logic [2*MW-1:0] a, input logic [MW-1:0] r, input int holdClks);
    fetchCount++;
    doAccess(3, a, holdClks);   // R4: same timing as a read
    doRefresh(r, 1);
  endtask

  task automatic runStimulus();
    repeat (3) @(negedge clk);
    check(rasN && casN && weN && !muxSel, "R1", "reset state",
          {rasN, casN, weN, muxSel}, 4'b1110);
    rstN = 1'b1;
    @(negedge clk);
    doFetch(16'h1234, 8'h00, 0);
    doAccess(0, 16'hBEEF, 0);
    doAccess(1, 16'h0F0F, 0);
    doFetch(16'h5A3C, 8'h01, 0);
    doAccess(1, 16'hFF00, 3);
    doFetch(16'h00FF, 8'h02, 2);
    doRefresh(8'h7F, 3);
    fetchCount++;
    doAccess(0, 16'h8001, 1);
    for (int i = 0; i < 6; i++) begin
      doFetch(16'h1000 + 16'(i * 16'h0111), 8'(8'h03 + i), i % 3);
      doAccess(i % 2, 16'hC000 + 16'(i), 0);
    end
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R9", "all expected cycles seen", expQ.size(), 0);
    check(refreshSeen == fetchCount, "R9", "one refresh per fetch", refreshSeen, fetchCount);
  endtask

  initial begin
    fork
      runStimulus();
      begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R9", "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule